// File: doc/BRIEF.md
# DMA Event Interrupt Register Block

This block keeps the event and interrupt state of a DMA engine that signals up to 32 numbered events. Each single-cycle pulse on the engine's event vector latches a raw status bit. If the event is enabled at that moment, the pulse also latches a masked status bit, and that bit drives the event's own interrupt line. The line stays high until software clears it.

Software reaches the block over a 32-bit word-access register bus. It can read and write an enable mask and read the raw status, the masked status and a configuration word that reports the event count. A clear register takes a bit mask on writes and reads back as zero. A clear acts only on bits that are both written as 1 and currently enabled, and it drops the raw and the masked bit together. An event that arrives in the same cycle as a clear of its bit is kept.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the enable mask, raw status and masked status are zero, every interrupt output is low and the read data bus is zero.
- R2: A write to byte offset 0x00 replaces the whole enable mask with the written value. A read of 0x00 returns the mask. Bits at or above NUM_EVENTS read as zero and ignore writes.
- R3: An event pulse on evPulse[i] sets raw status bit i (read at offset 0x04), whether or not event i is enabled.
- R4: An event pulse on evPulse[i] while enable bit i is 1 (the value held before that cycle's write) sets masked status bit i (read at offset 0x08). The bit stays set until it is cleared.
- R5: A write to offset 0x0C clears raw and masked bit i exactly where written bit i and enable bit i are both 1. Every other bit keeps its value.
- R6: Reads of offset 0x0C and of unmapped offsets return zero. Writes to the read-only offsets 0x04, 0x08 and 0x10, and to unmapped offsets, change nothing.
- R7: When an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Offset 0x10 reads a configuration word with NUM_EVENTS-1 in bits 21:17 and zero in every other bit.
- R9: irqOut[i] equals masked status bit i at all times.
- R10: Read data appears on busRdData in the cycle after the read strobe and shows the state from before that clock edge. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evPulse | input | NUM_EVENTS | One-cycle event pulses from the engine |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address of the word register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqOut | output | NUM_EVENTS | One interrupt line per event |

## Verification
The bench builds the block with NUM_EVENTS=8 on the 32-bit bus. The upper 24 bits of every write then fall on missing events, which shows that they are dropped and read back as zero, and the configuration field carries the value 7. Eight events are also few enough that random enable masks, clear masks and event patterns hit every mix of enabled, disabled, cleared and same-cycle bits within a few hundred cycles. A reference model checks each of those cycles.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Word index of each register (byte offset / 4)
  localparam int WIDX_ENABLE = 0;
  localparam int WIDX_RAW    = 1;
  localparam int WIDX_MASKED = 2;
  localparam int WIDX_CLEAR  = 3;
  localparam int WIDX_CONFIG = 4;

  // Bit position of the event-count field in the configuration word
  localparam int CFG_COUNT_LSB = 17;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED,
    SEL_CONFIG
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   wrEnable;
    logic   wrClear;
    logic   rdStrobe;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobes
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wordAddr;
  logic [1:0]      unusedByteBits;

  assign wordAddr       = busAddr[ADDR_W-1:2];
  assign unusedByteBits = busAddr[1:0];

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = SEL_ZERO;
    strobes.rdStrobe = busRdEn;
    strobes.wrEnable = busWrEn && (wordAddr == WA_W'(WIDX_ENABLE));
    strobes.wrClear  = busWrEn && (wordAddr == WA_W'(WIDX_CLEAR));
    if (wordAddr == WA_W'(WIDX_ENABLE))      strobes.rdSel = SEL_ENABLE;
    else if (wordAddr == WA_W'(WIDX_RAW))    strobes.rdSel = SEL_RAW;
    else if (wordAddr == WA_W'(WIDX_MASKED)) strobes.rdSel = SEL_MASKED;
    else if (wordAddr == WA_W'(WIDX_CONFIG)) strobes.rdSel = SEL_CONFIG;
    else                                     strobes.rdSel = SEL_ZERO;
  end

endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_EVENTS-1:0] evPulse,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_EVENTS-1:0] irqOut
);

  localparam logic [4:0]        COUNT_FIELD = 5'(NUM_EVENTS - 1);
  localparam logic [DATA_W-1:0] CFG_WORD    = DATA_W'(COUNT_FIELD) << CFG_COUNT_LSB;

  logic [NUM_EVENTS-1:0] enableReg;
  logic [NUM_EVENTS-1:0] rawReg;
  logic [NUM_EVENTS-1:0] maskReg;
  logic [DATA_W-1:0]     rdNext;
  logic                  unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN)                 enableReg <= '0;
    else if (strobes.wrEnable) enableReg <= wrData[NUM_EVENTS-1:0];
  end

  for (genvar g = 0; g < NUM_EVENTS; g++) begin : gBit
    logic clrBit;
    assign clrBit = strobes.wrClear & wrData[g] & enableReg[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rawReg[g]  <= 1'b0;
        maskReg[g] <= 1'b0;
      end else begin
        rawReg[g]  <= evPulse[g] | (rawReg[g] & ~clrBit);
        maskReg[g] <= (evPulse[g] & enableReg[g]) | (maskReg[g] & ~clrBit);
      end
    end

    assert_enabled_event_raises_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
      (evPulse[g] && enableReg[g]) |=> irqOut[g]);
    assert_event_sets_raw_R3: assert property (@(posedge clk) disable iff (!rstN)
      evPulse[g] |=> rawReg[g]);
    assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      (evPulse[g] && strobes.wrClear && wrData[g]) |=> (rawReg[g] && irqOut[g] == enableReg[g] | $past(maskReg[g] | enableReg[g])));
  end

  assign irqOut = maskReg;

  always_comb begin
    case (strobes.rdSel)
      SEL_ENABLE: rdNext = DATA_W'(enableReg);
      SEL_RAW:    rdNext = DATA_W'(rawReg);
      SEL_MASKED: rdNext = DATA_W'(maskReg);
      SEL_CONFIG: rdNext = CFG_WORD;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= rdNext;
  end

  assert_enable_replaced_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEnable |=> (enableReg == $past(wrData[NUM_EVENTS-1:0])));
  assert_clear_drops_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrClear |=> ((rawReg & $past(wrData[NUM_EVENTS-1:0] & enableReg & ~evPulse)) == '0));
  assert_no_drop_without_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrClear |=> (($past(rawReg) & ~rawReg) == '0));
  assert_masked_within_raw_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~rawReg) == '0));
  assert_zero_readback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdSel == SEL_ZERO) |=> (rdData == '0));
  assert_config_field_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdSel == SEL_CONFIG) |=> (rdData[21:17] == COUNT_FIELD));

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evPulse,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic [NUM_EVENTS-1:0] irqOut
);

  localparam int DATA_W = 32;

  regStrobe_t strobes;

  evt_irq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  evt_irq_datapath #(.NUM_EVENTS(NUM_EVENTS), .DATA_W(DATA_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .evPulse (evPulse),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/test_evt_irq_regs.sv
module test_evt_irq_regs;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] evPulse = '0;
  logic         busWrEn = 1'b0;
  logic         busRdEn = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic [N-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [N-1:0] mEn = '0, mRaw = '0, mMask = '0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdFlag = 1'b0;

  always #4ns clk = ~clk;

  evt_irq_regs #(.NUM_EVENTS(N), .ADDR_W(8)) i_evt_irq_regs (
    .clk(clk), .rstN(rstN), .evPulse(evPulse), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a & 8'hFC)
      8'h00: return 32'(mEn);
      8'h04: return 32'(mRaw);
      8'h08: return 32'(mMask);
      8'h10: return 32'(N - 1) << 17;
      default: return 32'h0;
    endcase
  endfunction

  // driver: one bus cycle plus event vector
  task automatic step(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                      input logic re, input logic [7:0] ra, input logic [N-1:0] ev,
                      input string tag);
    logic [N-1:0] clr;
    @(negedge clk);
    chk(irqOut == mMask, "R9 irq equals masked status", 32'(irqOut), 32'(mMask));
    busWrEn   = we;
    busAddr   = we ? wa : ra;
    busWrData = wd;
    busRdEn   = re;
    evPulse   = ev;
    if (we && re) busAddr = wa;
    if (re) begin
      expQ.push_back(expRead(busAddr));
      tagQ.push_back(tag);
    end
    clr   = (we && (wa & 8'hFC) == 8'h0C) ? (wd[N-1:0] & mEn) : '0;
    mMask = (mMask & ~clr) | (ev & mEn);
    mRaw  = (mRaw & ~clr) | ev;
    if (we && (wa & 8'hFC) == 8'h00) mEn = wd[N-1:0];
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] ev, input string tag);
    step(1'b1, a, d, 1'b0, 8'h0, ev, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 8'h0, 32'h0, 1'b1, a, '0, tag);
  endtask

  // monitor: compare registered read data one cycle after each strobe
  always @(posedge clk) rdFlag <= busRdEn && rstN;

  always @(negedge clk) begin
    if (rdFlag) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected read", busRdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(busRdData === e, t, busRdData, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(irqOut == '0, "R1 irq low after reset", 32'(irqOut), 32'h0);
    chk(busRdData == '0, "R1 read data zero after reset", busRdData, 32'h0);
    rd(8'h00, "R1 enable zero");
    rd(8'h04, "R1 raw zero");
    rd(8'h08, "R1 masked zero");

    wr(8'h00, 32'hFFFF_FFA5, '0, "R2 write enable");
    rd(8'h00, "R2 enable readback, upper bits zero");
    rd(8'h10, "R8 config word");
    rd(8'h0C, "R6 clear reads zero");
    rd(8'h14, "R6 unmapped reads zero");
    wr(8'h04, 32'hFFFF_FFFF, '0, "R6 write raw ignored");
    wr(8'h08, 32'hFFFF_FFFF, '0, "R6 write masked ignored");
    wr(8'h10, 32'hFFFF_FFFF, '0, "R6 write config ignored");
    rd(8'h04, "R6 raw unchanged");
    rd(8'h10, "R6 config unchanged");

    step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 8'hFF, "R3 pulse all");
    rd(8'h04, "R3 raw set for all");
    rd(8'h08, "R4 masked only enabled");
    rd(8'h09, "R10 low address bits ignored");
    wr(8'h0C, 32'h0000_000F, '0, "R5 clear");
    rd(8'h04, "R5 raw after clear");
    rd(8'h08, "R5 masked after clear");

    wr(8'h00, 32'h0000_00FF, '0, "R7 enable all");
    step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 8'h3C, "R7 set");
    step(1'b1, 8'h0C, 32'h0000_00FF, 1'b0, 8'h0, 8'h30, "R7 pulse with clear");
    rd(8'h04, "R7 raw kept by event");
    rd(8'h08, "R7 masked kept by event");
    step(1'b1, 8'h00, 32'h0000_0000, 1'b0, 8'h0, 8'h01, "R4 old enable used");
    rd(8'h08, "R4 masked with old enable");

    for (int k = 0; k < 400; k++) begin
      logic [7:0] wa, ra;
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 2));
      wa = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h0C : 8'h04;
      ra = 8'($urandom_range(0, 5) * 4);
      step(1'($urandom), wa, $urandom, 1'($urandom), ra, N'($urandom & $urandom),
           "R5 R7 random");
    end

    rd(8'h08, "R4 final masked");
    step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, '0, "idle");
    step(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, '0, "idle");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule